// File: doc/BRIEF.md
# Host Parallel Port with Byte and Nibble Transfers

This block is the slave side of a parallel microprocessor bus built from three strobes (register select, read/not-write, enable) and an 8-bit data bus split into separate input and output halves with an output-enable. The host's enable signal is sampled by the system clock. Every transfer is taken on the falling edge of enable. The register-select and direction lines pick one of four operations: command write, status read, data write and data read.

The port works either a whole byte at a time or, on the upper four data lines only, a nibble at a time. In nibble mode the high half goes first and the low half second. A single phase toggle, shared by reads and writes, tracks which half comes next. A completed write is handed to an executor as a one-cycle strobe that carries the value and the register-select level. A completed data read produces a one-cycle strobe so the executor can advance its address. Status reads return the executor's busy indication together with its 7-bit address counter. A width-select command switches the mode at run time.

Top module: `host_par_port`

## Requirements
- R1: A transfer with select=0 and direction=0 is a command write. When the byte completes, `byte_stb` pulses with `byte_is_data`=0 and `byte_val` equal to the byte.
- R2: A transfer with select=1 and direction=0 is a data write. When the byte completes, `byte_stb` pulses with `byte_is_data`=1 and `byte_val` equal to the byte.
- R3: A read with select=0 returns the busy input on bit 7 and the 7-bit address counter on bits 6..0. There is no path that returns a written command.
- R4: A read with select=1 returns `exe_rdata`. `rd_stb` pulses for one cycle after the falling enable edge that ends a full data read, and never after a status read.
- R5: Inputs are taken on the system-clock edge that sees enable fall. `byte_stb` and `rd_stb` are high in the following cycle only.
- R6: `bus_oe` is high only while enable is high with direction=1. Whenever it is low, `bus_dout` is all zeros.
- R7: After reset the port is in byte mode. A command byte whose bits 7..5 are 001 sets the mode from bit 4: 1 selects byte mode and 0 selects nibble mode.
- R8: In nibble mode, a write carries its value on data bits 7..4 and the low input lines are ignored. The first transfer is the high half and produces no strobe. The second transfer is the low half and produces the strobe with the joined byte.
- R9: In nibble mode, the first read shows the high half of the selected word on bits 7..4. The second read shows the low half as it stood at the end of the first read. Bits 3..0 read as zero in both.
- R10: A write whose enable falls while `exe_busy` is high is ignored. It produces no strobe and does not advance the nibble phase.
- R11: A change of mode leaves the phase at the high half, so the next transfer after a width switch starts a fresh byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_en | input | 1 | Host transfer enable; taken on its falling edge |
| bus_rs | input | 1 | Register select: 0 command/status, 1 data |
| bus_rnw | input | 1 | Direction: 1 read, 0 write |
| bus_din | input | 8 | Data lines from the host |
| bus_dout | output | 8 | Data lines to the host |
| bus_oe | output | 1 | Output enable for `bus_dout` |
| exe_busy | input | 1 | Executor busy indication |
| exe_ac | input | 7 | Executor address counter |
| exe_rdata | input | 8 | Executor read data |
| byte_stb | output | 1 | One-cycle strobe for a completed write |
| byte_is_data | output | 1 | Register-select level of the strobed byte |
| byte_val | output | 8 | Completed write byte |
| rd_stb | output | 1 | One-cycle strobe for a completed data read |

## Verification
The assertions check on every cycle that strobes only follow an enable fall, that a busy write neither strobes nor moves the phase, and that byte mode never holds a pending half. They also check that the bus is quiet while it is not driven, that the low read lines stay zero in nibble mode, and that a mode change leaves the phase at the high half. Only the bench's scenarios can show the values themselves. These are the bytes joined from two nibbles, the busy/address packing, the read snapshot held across a change of the executor's inputs, and the mode switches in both directions driven by command bytes.

// File: rtl/hbi_pkg.sv
package hbi_pkg;
  localparam int unsigned BUS_W  = 8;
  localparam int unsigned NIB_W  = BUS_W / 2;
  localparam int unsigned AC_W   = BUS_W - 1;
  localparam int unsigned DL_BIT = 4;

  typedef enum logic [1:0] {
    OP_CMD_WR  = 2'b00,
    OP_STAT_RD = 2'b01,
    OP_DAT_WR  = 2'b10,
    OP_DAT_RD  = 2'b11
  } bus_op_e;

  function automatic bus_op_e decode_op(input logic rs, input logic rnw);
    return bus_op_e'({rs, rnw});
  endfunction

  function automatic logic [BUS_W-1:0] status_word(input logic busy, input logic [AC_W-1:0] ac);
    return {busy, ac};
  endfunction

  function automatic logic is_width_cmd(input logic [BUS_W-1:0] b);
    return b[BUS_W-1 -: 3] == 3'b001;
  endfunction

  function automatic logic [BUS_W-1:0] nib_join(input logic [NIB_W-1:0] hi, input logic [NIB_W-1:0] lo);
    return {hi, lo};
  endfunction
endpackage

// File: rtl/hbi_edge.sv
module hbi_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic fall
);
  logic en_q;

  always_ff @(posedge clk) begin
    if (!rst_n) en_q <= 1'b0;
    else        en_q <= en;
  end

  assign fall = en_q & ~en;
endmodule

// File: rtl/hbi_nibble.sv
module hbi_nibble
  import hbi_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fall,
  input  logic             rs,
  input  logic             rnw,
  input  logic [BUS_W-1:0] din,
  input  logic             busy,
  input  logic [NIB_W-1:0] live_lo,
  output logic             wide_mode,
  output logic             phase_lo,
  output logic [NIB_W-1:0] snap_lo,
  output logic             byte_stb,
  output logic             byte_is_data,
  output logic [BUS_W-1:0] byte_val,
  output logic             rd_stb
);
  logic [NIB_W-1:0] hi_q;
  bus_op_e          op;
  logic             is_rd, wr_take, xfer_last;
  logic [BUS_W-1:0] wr_byte;

  always_comb begin
    op        = decode_op(rs, rnw);
    is_rd     = (op == OP_STAT_RD) || (op == OP_DAT_RD);
    wr_take   = !is_rd && !busy;
    xfer_last = wide_mode || phase_lo;
    wr_byte   = wide_mode ? din : nib_join(hi_q, din[BUS_W-1 -: NIB_W]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wide_mode    <= 1'b1;
      phase_lo     <= 1'b0;
      hi_q         <= '0;
      snap_lo      <= '0;
      byte_stb     <= 1'b0;
      byte_is_data <= 1'b0;
      byte_val     <= '0;
      rd_stb       <= 1'b0;
    end else begin
      byte_stb <= 1'b0;
      rd_stb   <= 1'b0;
      if (fall) begin
        if (wr_take) begin
          if (xfer_last) begin
            byte_stb     <= 1'b1;
            byte_is_data <= rs;
            byte_val     <= wr_byte;
            phase_lo     <= 1'b0;
            if (!rs && is_width_cmd(wr_byte)) wide_mode <= wr_byte[DL_BIT];
          end else begin
            hi_q     <= din[BUS_W-1 -: NIB_W];
            phase_lo <= 1'b1;
          end
        end else if (is_rd) begin
          if (xfer_last) begin
            rd_stb   <= (op == OP_DAT_RD);
            phase_lo <= 1'b0;
          end else begin
            snap_lo  <= live_lo;
            phase_lo <= 1'b1;
          end
        end
      end
    end
  end

  AST_STB_AFTER_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    byte_stb |-> $past(fall)); // R5
  AST_RDSTB_AFTER_DATA_READ: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stb |-> $past(fall && rnw && rs)); // R4
  AST_BUSY_NO_STB: assert property (@(posedge clk) disable iff (!rst_n)
    (fall && !rnw && busy) |=> !byte_stb); // R10
  AST_BUSY_PHASE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (fall && !rnw && busy) |=> $stable(phase_lo)); // R10
  AST_WIDE_NO_HALF: assert property (@(posedge clk) disable iff (!rst_n)
    wide_mode |-> !phase_lo); // R8
  AST_SWITCH_PHASE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (wide_mode != $past(wide_mode)) |-> !phase_lo); // R11
endmodule

// File: rtl/hbi_rdmux.sv
module hbi_rdmux
  import hbi_pkg::*;
(
  input  logic             oe,
  input  logic             wide_mode,
  input  logic             phase_lo,
  input  logic [BUS_W-1:0] live,
  input  logic [NIB_W-1:0] snap_lo,
  output logic [BUS_W-1:0] dout
);
  always_comb begin
    if (!oe)            dout = '0;
    else if (wide_mode) dout = live;
    else if (phase_lo)  dout = {snap_lo, {NIB_W{1'b0}}};
    else                dout = {live[BUS_W-1 -: NIB_W], {NIB_W{1'b0}}};
  end
endmodule

// File: rtl/host_par_port.sv
module host_par_port
  import hbi_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_en,
  input  logic             bus_rs,
  input  logic             bus_rnw,
  input  logic [BUS_W-1:0] bus_din,
  output logic [BUS_W-1:0] bus_dout,
  output logic             bus_oe,
  input  logic             exe_busy,
  input  logic [AC_W-1:0]  exe_ac,
  input  logic [BUS_W-1:0] exe_rdata,
  output logic             byte_stb,
  output logic             byte_is_data,
  output logic [BUS_W-1:0] byte_val,
  output logic             rd_stb
);
  logic             en_fall;
  logic             wide_mode, phase_lo;
  logic [NIB_W-1:0] snap_lo;
  logic [BUS_W-1:0] rd_live;

  assign bus_oe  = bus_en & bus_rnw;
  assign rd_live = bus_rs ? exe_rdata : status_word(exe_busy, exe_ac);

  hbi_edge u_edge (
    .clk  (clk),
    .rst_n(rst_n),
    .en   (bus_en),
    .fall (en_fall)
  );

  hbi_nibble u_nib (
    .clk         (clk),
    .rst_n       (rst_n),
    .fall        (en_fall),
    .rs          (bus_rs),
    .rnw         (bus_rnw),
    .din         (bus_din),
    .busy        (exe_busy),
    .live_lo     (rd_live[NIB_W-1:0]),
    .wide_mode   (wide_mode),
    .phase_lo    (phase_lo),
    .snap_lo     (snap_lo),
    .byte_stb    (byte_stb),
    .byte_is_data(byte_is_data),
    .byte_val    (byte_val),
    .rd_stb      (rd_stb)
  );

  hbi_rdmux u_mux (
    .oe       (bus_oe),
    .wide_mode(wide_mode),
    .phase_lo (phase_lo),
    .live     (rd_live),
    .snap_lo  (snap_lo),
    .dout     (bus_dout)
  );

  AST_DOUT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_oe |-> (bus_dout == '0)); // R6
  AST_NIB_LOW_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_oe && !wide_mode) |-> (bus_dout[NIB_W-1:0] == '0)); // R9
endmodule

// File: tb/tb_host_par_port.sv
module tb_host_par_port;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_en = 1'b0, bus_rs = 1'b0, bus_rnw = 1'b0;
  logic [7:0] bus_din = '0;
  logic [7:0] bus_dout;
  logic       bus_oe;
  logic       exe_busy = 1'b0;
  logic [6:0] exe_ac = '0;
  logic [7:0] exe_rdata = '0;
  logic       byte_stb, byte_is_data, rd_stb;
  logic [7:0] byte_val;

  int  n_chk = 0, n_err = 0;
  bit  done = 0;
  bit  m8 = 1;
  logic       s_stb, s_dat;
  logic [7:0] s_val;

  always #(CLK_PERIOD/2) clk = ~clk;

  host_par_port dut (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_rs(bus_rs), .bus_rnw(bus_rnw),
    .bus_din(bus_din), .bus_dout(bus_dout), .bus_oe(bus_oe), .exe_busy(exe_busy),
    .exe_ac(exe_ac), .exe_rdata(exe_rdata), .byte_stb(byte_stb),
    .byte_is_data(byte_is_data), .byte_val(byte_val), .rd_stb(rd_stb)
  );

  function automatic logic [7:0] exp_word(input logic rs, input logic busy,
                                          input logic [6:0] ac, input logic [7:0] rd);
    if (rs) return rd;
    return {busy, ac};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // One enable pulse for a write; results of the cycle after the fall go to s_*
  task automatic xfer_wr(input logic rs, input logic [7:0] d);
    @(negedge clk); bus_rs = rs; bus_rnw = 1'b0; bus_din = d; bus_en = 1'b1;
    @(negedge clk);
    chk(!bus_oe && bus_dout == 8'h00, "R6 write drives bus", {7'd0, bus_oe, bus_dout}, 16'h0);
    @(negedge clk); bus_en = 1'b0;
    @(negedge clk); s_stb = byte_stb; s_dat = byte_is_data; s_val = byte_val;
    @(negedge clk);
    chk(!byte_stb, "R5 strobe single cycle", {15'd0, byte_stb}, 16'h0);
  endtask

  task automatic wr_byte(input logic rs, input logic [7:0] d);
    string tg;
    tg = rs ? "R2" : "R1";
    if (m8) begin
      xfer_wr(rs, d);
    end else begin
      xfer_wr(rs, {d[7:4], 4'($urandom)});
      chk(!s_stb, "R8 strobe after first half", {15'd0, s_stb}, 16'h0);
      xfer_wr(rs, {d[3:0], 4'($urandom)});
      tg = {tg, "/R8"};
    end
    chk(s_stb && s_dat == rs && s_val == d, tg, {6'd0, s_stb, s_dat, s_val}, {7'd1, rs, d});
    if (!rs && d[7:5] == 3'b001) m8 = d[4];
  endtask

  task automatic xfer_rd(input logic rs, output logic [7:0] seen, output logic stb_seen);
    @(negedge clk); bus_rs = rs; bus_rnw = 1'b1; bus_en = 1'b1;
    @(negedge clk); seen = bus_dout;
    chk(bus_oe, "R6 read not driven", {15'd0, bus_oe}, 16'h1);
    bus_en = 1'b0;
    @(negedge clk); stb_seen = rd_stb;
    chk(!bus_oe && bus_dout == 8'h00, "R6 bus after read", {7'd0, bus_oe, bus_dout}, 16'h0);
  endtask

  task automatic rd_byte(input logic rs);
    logic [7:0] w, got;
    logic st;
    w = exp_word(rs, exe_busy, exe_ac, exe_rdata);
    if (m8) begin
      xfer_rd(rs, got, st);
      chk(got == w, rs ? "R4 data read" : "R3 status read", {8'd0, got}, {8'd0, w});
    end else begin
      xfer_rd(rs, got, st);
      chk(got == {w[7:4], 4'h0}, "R9 high half", {8'd0, got}, {8'd0, w[7:4], 4'h0});
      chk(!st, "R4 strobe after first half", {15'd0, st}, 16'h0);
      exe_rdata = 8'($urandom); exe_ac = 7'($urandom); exe_busy = 1'($urandom);
      xfer_rd(rs, got, st);
      chk(got == {w[3:0], 4'h0}, "R9 low half snapshot", {8'd0, got}, {8'd0, w[3:0], 4'h0});
    end
    chk(st == rs, "R4 read strobe", {15'd0, st}, {15'd0, rs});
  endtask

  initial begin
    repeat (CLK_PERIOD * 15000) @(posedge clk);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!bus_oe && bus_dout == 0 && !byte_stb && !rd_stb, "R6 reset state",
        {5'd0, bus_oe, byte_stb, rd_stb, bus_dout}, 16'h0);

    // R7: byte mode after reset
    wr_byte(1'b0, 8'h01);
    wr_byte(1'b1, 8'hA5);
    exe_busy = 1'b1; exe_ac = 7'h35;
    rd_byte(1'b0);                       // R3 expect B5
    exe_busy = 1'b0; exe_rdata = 8'h3C;
    rd_byte(1'b1);                       // R4

    // R10: write while busy in byte mode
    exe_busy = 1'b1;
    xfer_wr(1'b1, 8'h77);
    chk(!s_stb, "R10 busy write strobed", {15'd0, s_stb}, 16'h0);
    exe_busy = 1'b0;

    // R7: switch to nibble mode
    wr_byte(1'b0, 8'h28);
    chk(m8 == 0, "R7 model", {15'd0, m8}, 16'h0);
    // R10/R11: busy first half ignored, phase stays at high half
    exe_busy = 1'b1;
    xfer_wr(1'b1, 8'hF0);
    chk(!s_stb, "R10 busy half strobed", {15'd0, s_stb}, 16'h0);
    exe_busy = 1'b0;
    wr_byte(1'b1, 8'h5A);
    exe_rdata = 8'hC6;
    rd_byte(1'b1);                       // R9
    exe_busy = 1'b1; exe_ac = 7'h4B;
    rd_byte(1'b0);                       // R3 + R9
    exe_busy = 1'b0;

    // R7/R11: back to byte mode, next single transfer completes a byte
    wr_byte(1'b0, 8'h30);
    xfer_wr(1'b1, 8'h9E);
    chk(s_stb && s_val == 8'h9E, "R11 first transfer after switch",
        {7'd0, s_stb, s_val}, {8'd1, 8'h9E});

    // Random mix
    for (int i = 0; i < 400; i++) begin
      exe_ac = 7'($urandom); exe_rdata = 8'($urandom); exe_busy = 1'($urandom);
      case ($urandom % 4)
        0: begin exe_busy = 1'b0; d = 8'($urandom); wr_byte(1'b0, d); end
        1: begin exe_busy = 1'b0; d = 8'($urandom); wr_byte(1'b1, d); end
        2: rd_byte(1'b0);
        default: rd_byte(1'b1);
      endcase
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule